// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept. The destination address arrives one byte per cycle, first byte on the wire first. One cycle after the last destination byte the block reports whether the address is wanted. The address can be wanted through an exact match against the station address, through promiscuous mode for unicast, through the broadcast enable, or through a 64-entry multicast hash table. The hash index comes from a CRC-32 that the block computes over the destination bytes as they arrive.

At end of frame the block applies the length and error policies and monitor mode. It then issues a one-cycle result: whether the frame is stored, and a set of status bits (good, CRC error, alignment error, missed, group address). A separate level output shows that the receiver is in monitor mode. Byte deserialisation and buffer storage belong to neighbouring blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: A destination whose first byte has bit 0 clear is a unicast address. After the sixth destination byte is taken (`da_valid`, with `da_first` on the first byte), `addr_dec_valid` pulses for one cycle in the next cycle. With `cfg_promisc` low, `addr_hit` is then 1 only when the six bytes equal `station_addr`, where the first byte on the wire is compared with `station_addr[47:40]` and the last with `station_addr[7:0]`.
- R2: With `cfg_promisc` high, every unicast destination gives `addr_hit` = 1.
- R3: The all-ones destination is broadcast. It gives `addr_hit` = 1 only when `cfg_take_bcast` is high, whatever `cfg_promisc` is.
- R4: A non-broadcast destination whose first byte has bit 0 set is multicast. It gives `addr_hit` = 1 only when `cfg_take_mcast` is high and `hash_table[k]` is 1. To form k, a CRC register starts at all ones and takes each byte least significant bit first, in wire order. Each bit step shifts the register left and XORs in 0x04C11DB7 when the old bit 31 XOR the data bit is 1. k is bits 31:26 of the final register, with no inversion.
- R5: `addr_group` is 0 for unicast and 1 for broadcast or multicast. It is valid with `addr_dec_valid` and is repeated as `st_group` in the end-of-frame result.
- R6: A frame with `frame_len` below 64 is not stored unless `cfg_keep_short` is high. A length of exactly 64 is not short.
- R7: A frame flagged with `crc_err` or `align_err` is not stored unless `cfg_keep_err` is high. `st_crc` is 1 for either error. `st_align` is 1 only for an alignment error.
- R8: While `cfg_monitor` is high, no frame is stored. A frame that passes every other check reports `st_missed` = 1 instead. `rx_off` follows `cfg_monitor` one cycle later and stays high as long as monitor mode is on.
- R9: The end-of-frame result appears one cycle after the `eof` pulse. `done_valid` and all result bits are pulses in that cycle only. `st_good` is 1 when the frame is stored and has no error.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_promisc | input | 1 | Accept any unicast destination |
| cfg_take_bcast | input | 1 | Accept broadcast |
| cfg_take_mcast | input | 1 | Accept multicast through the hash table |
| cfg_keep_short | input | 1 | Keep frames shorter than 64 bytes |
| cfg_keep_err | input | 1 | Keep frames with CRC or alignment errors |
| cfg_monitor | input | 1 | Check frames but never store them |
| station_addr | input | 48 | Station address, first wire byte in [47:40] |
| hash_table | input | 64 | Multicast hash bits |
| da_valid | input | 1 | Destination byte present |
| da_first | input | 1 | First destination byte of a frame |
| da_byte | input | 8 | Destination byte |
| eof | input | 1 | End-of-frame pulse |
| frame_len | input | 16 | Frame length in bytes, valid with eof |
| crc_err | input | 1 | Frame CRC error, valid with eof |
| align_err | input | 1 | Frame alignment error, valid with eof |
| addr_dec_valid | output | 1 | Address decision pulse |
| addr_hit | output | 1 | Destination wanted |
| addr_group | output | 1 | Destination is broadcast or multicast |
| done_valid | output | 1 | End-of-frame result pulse |
| frame_store | output | 1 | Frame is to be stored |
| st_good | output | 1 | Stored without error |
| st_crc | output | 1 | CRC or alignment error seen |
| st_align | output | 1 | Alignment error seen |
| st_missed | output | 1 | Frame passed but was not stored because of monitor mode |
| st_group | output | 1 | Group-address frame |
| rx_off | output | 1 | Receiver in monitor mode |

## Verification
The address path is tried with four kinds of input pattern:
- An exact station match, and addresses that differ only in the first or only in the last byte. These separate a full compare from a partial one and show the byte order.
- The all-ones address with the broadcast enable on and off. This separates broadcast from multicast, since both have bit 0 set.
- Two multicast addresses, with a table that holds only one bit and with its complement. This pins down the computed hash index, not just any bit being set.
- A non-matching unicast address with promiscuous mode on and off.

The frame policies are tried at lengths 63 and 64, with each error flag alone, and under monitor mode. These show the runt boundary, the separate error status bits, and that a missed frame is reported in place of a stored one.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // One byte into a left-shifting CRC-32, bits taken LSB first
  function automatic logic [31:0] crc_add_byte(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic frame_is_short(logic [15:0] len, int unsigned min_len);
    return 32'(len) < min_len;
  endfunction
endpackage

// File: rtl/rx_dest_collect.sv
module rx_dest_collect #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64,
  localparam int ADDR_W = ADDR_BYTES * 8,
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1),
  localparam int HIDX_W = $clog2(HASH_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              da_valid,
  input  logic              da_first,
  input  logic [7:0]        da_byte,
  output logic              last_byte,
  output logic [ADDR_W-1:0] addr_next,
  output logic [HIDX_W-1:0] hash_idx
);
  import rx_filt_pkg::*;

  logic [CNT_W-1:0]  cnt_q, cnt_cur;
  logic [ADDR_W-1:0] addr_q, addr_base;
  logic [31:0]       crc_q, crc_base, crc_n;
  logic              take;

  always_comb begin
    cnt_cur   = da_first ? '0 : cnt_q;
    addr_base = da_first ? '0 : addr_q;
    crc_base  = da_first ? '1 : crc_q;
    take      = da_valid && (cnt_cur < CNT_W'(ADDR_BYTES));
    addr_next = {addr_base[ADDR_W-9:0], da_byte};
    crc_n     = crc_add_byte(crc_base, da_byte);
    hash_idx  = crc_n[31 -: HIDX_W];
    last_byte = take && (cnt_cur == CNT_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      crc_q  <= '1;
    end else if (take) begin
      cnt_q  <= cnt_cur + 1'b1;
      addr_q <= addr_next;
      crc_q  <= crc_n;
    end
  end

  // R1: the byte count never runs past the address length
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64,
  localparam int ADDR_W = ADDR_BYTES * 8,
  localparam int HIDX_W = $clog2(HASH_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_frame,
  input  logic              last_byte,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [HIDX_W-1:0] hash_idx,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [HASH_BITS-1:0] hash_table,
  input  logic              cfg_promisc,
  input  logic              cfg_take_bcast,
  input  logic              cfg_take_mcast,
  output logic              dec_valid,
  output logic              hit,
  output logic              grp
);
  logic is_bcast, is_grp, hit_c;

  always_comb begin
    is_bcast = &addr_in;
    is_grp   = addr_in[ADDR_W-8];
    if (is_bcast)    hit_c = cfg_take_bcast;
    else if (is_grp) hit_c = cfg_take_mcast && hash_table[hash_idx];
    else             hit_c = cfg_promisc || (addr_in == station_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      hit       <= 1'b0;
      grp       <= 1'b0;
    end else begin
      dec_valid <= last_byte;
      if (last_byte) begin
        hit <= hit_c;
        grp <= is_grp;
      end else if (new_frame) begin
        hit <= 1'b0;
        grp <= 1'b0;
      end
    end
  end

  // R1
  dec_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> dec_valid);
  // R3
  bcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && (&addr_in) && !cfg_take_bcast) |=> !hit);
  // R5
  group_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> (grp == $past(addr_in[ADDR_W-8])));
endmodule

// File: rtl/rx_frame_policy.sv
module rx_frame_policy #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             crc_err,
  input  logic             align_err,
  input  logic             addr_hit,
  input  logic             addr_grp,
  input  logic             cfg_keep_short,
  input  logic             cfg_keep_err,
  input  logic             cfg_monitor,
  output logic             done_valid,
  output logic             frame_store,
  output logic             st_good,
  output logic             st_crc,
  output logic             st_align,
  output logic             st_missed,
  output logic             st_group,
  output logic             rx_off
);
  import rx_filt_pkg::*;

  logic short_f, err_f, pass_f;

  always_comb begin
    short_f = frame_is_short(16'(frame_len), MIN_LEN);
    err_f   = crc_err || align_err;
    pass_f  = addr_hit && (!short_f || cfg_keep_short) && (!err_f || cfg_keep_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid  <= 1'b0;
      frame_store <= 1'b0;
      st_good     <= 1'b0;
      st_crc      <= 1'b0;
      st_align    <= 1'b0;
      st_missed   <= 1'b0;
      st_group    <= 1'b0;
      rx_off      <= 1'b0;
    end else begin
      rx_off      <= cfg_monitor;
      done_valid  <= eof;
      frame_store <= eof && pass_f && !cfg_monitor;
      st_good     <= eof && pass_f && !cfg_monitor && !err_f;
      st_crc      <= eof && err_f;
      st_align    <= eof && align_err;
      st_missed   <= eof && pass_f && cfg_monitor;
      st_group    <= eof && addr_grp;
    end
  end

  // R6
  runt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && (frame_len < LEN_W'(MIN_LEN)) && !cfg_keep_short) |=> !frame_store);
  // R7
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && (crc_err || align_err) && !cfg_keep_err) |=> !frame_store);
  // R7
  align_implies_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_align |-> st_crc);
  // R8
  monitor_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_store |-> !rx_off);
  // R8
  missed_xor_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_store && st_missed));
  // R9
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> done_valid);
  // R9
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_valid |-> !(frame_store || st_crc || st_missed || st_group));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 64,
  localparam int ADDR_W = ADDR_BYTES * 8,
  localparam int HIDX_W = $clog2(HASH_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_promisc,
  input  logic                 cfg_take_bcast,
  input  logic                 cfg_take_mcast,
  input  logic                 cfg_keep_short,
  input  logic                 cfg_keep_err,
  input  logic                 cfg_monitor,
  input  logic [ADDR_W-1:0]    station_addr,
  input  logic [HASH_BITS-1:0] hash_table,
  input  logic                 da_valid,
  input  logic                 da_first,
  input  logic [7:0]           da_byte,
  input  logic                 eof,
  input  logic [LEN_W-1:0]     frame_len,
  input  logic                 crc_err,
  input  logic                 align_err,
  output logic                 addr_dec_valid,
  output logic                 addr_hit,
  output logic                 addr_group,
  output logic                 done_valid,
  output logic                 frame_store,
  output logic                 st_good,
  output logic                 st_crc,
  output logic                 st_align,
  output logic                 st_missed,
  output logic                 st_group,
  output logic                 rx_off
);
  logic              last_byte_w;
  logic [ADDR_W-1:0] addr_next_w;
  logic [HIDX_W-1:0] hash_idx_w;
  logic              new_frame_w;

  assign new_frame_w = da_valid && da_first;

  rx_dest_collect #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_collect (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_first(da_first),
    .da_byte(da_byte), .last_byte(last_byte_w), .addr_next(addr_next_w),
    .hash_idx(hash_idx_w));

  rx_addr_match #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_match (
    .clk(clk), .rst_n(rst_n), .new_frame(new_frame_w), .last_byte(last_byte_w),
    .addr_in(addr_next_w), .hash_idx(hash_idx_w), .station_addr(station_addr),
    .hash_table(hash_table), .cfg_promisc(cfg_promisc),
    .cfg_take_bcast(cfg_take_bcast), .cfg_take_mcast(cfg_take_mcast),
    .dec_valid(addr_dec_valid), .hit(addr_hit), .grp(addr_group));

  rx_frame_policy #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_policy (
    .clk(clk), .rst_n(rst_n), .eof(eof), .frame_len(frame_len),
    .crc_err(crc_err), .align_err(align_err), .addr_hit(addr_hit),
    .addr_grp(addr_group), .cfg_keep_short(cfg_keep_short),
    .cfg_keep_err(cfg_keep_err), .cfg_monitor(cfg_monitor),
    .done_valid(done_valid), .frame_store(frame_store), .st_good(st_good),
    .st_crc(st_crc), .st_align(st_align), .st_missed(st_missed),
    .st_group(st_group), .rx_off(rx_off));

  // R10: nothing is reported in the first cycle after reset
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(addr_dec_valid || done_valid || frame_store));
  // R9: a stored frame always had its address wanted
  store_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_store |-> addr_hit);
endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_promisc = 0, cfg_take_bcast = 0, cfg_take_mcast = 0;
  logic cfg_keep_short = 0, cfg_keep_err = 0, cfg_monitor = 0;
  logic [47:0] station_addr = 48'h021A2B3C4D5E;
  logic [63:0] hash_table = '0;
  logic da_valid = 0, da_first = 0;
  logic [7:0] da_byte = '0;
  logic eof = 0;
  logic [15:0] frame_len = '0;
  logic crc_err = 0, align_err = 0;
  logic addr_dec_valid, addr_hit, addr_group, done_valid, frame_store;
  logic st_good, st_crc, st_align, st_missed, st_group, rx_off;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  rx_addr_filter u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Hash index via the bit-reversed (right-shifting) CRC form
  function automatic logic [5:0] ref_idx(logic [47:0] a);
    logic [31:0] r;
    logic [7:0] b;
    r = 32'hFFFFFFFF;
    for (int n = 0; n < 6; n++) begin
      b = a[47-8*n -: 8];
      for (int i = 0; i < 8; i++)
        r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic logic ref_hit(logic [47:0] a);
    if (a == 48'hFFFFFFFFFFFF) return cfg_take_bcast;
    if (a[40]) return cfg_take_mcast && hash_table[ref_idx(a)];
    return cfg_promisc || (a == station_addr);
  endfunction

  task automatic send_addr(logic [47:0] a, string req);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      da_valid = 1; da_first = (n == 0); da_byte = a[47-8*n -: 8];
    end
    @(negedge clk);
    da_valid = 0; da_first = 0;
    check({req, " dec_valid"}, 32'(addr_dec_valid), 1);
    check({req, " hit"}, 32'(addr_hit), 32'(ref_hit(a)));
    check({req, " group"}, 32'(addr_group), 32'(a[40]));
  endtask

  task automatic end_frame(logic [47:0] a, int len, bit ce, bit ae, string req);
    logic pass;
    pass = ref_hit(a) && (len >= 64 || cfg_keep_short) && (!(ce || ae) || cfg_keep_err);
    eof = 1; frame_len = 16'(len); crc_err = ce; align_err = ae;
    @(negedge clk);
    eof = 0; crc_err = 0; align_err = 0;
    check({req, " done_valid"}, 32'(done_valid), 1);
    check({req, " store"}, 32'(frame_store), 32'(pass && !cfg_monitor));
    check({req, " good"}, 32'(st_good), 32'(pass && !cfg_monitor && !(ce || ae)));
    check({req, " crc"}, 32'(st_crc), 32'(ce || ae));
    check({req, " align"}, 32'(st_align), 32'(ae));
    check({req, " missed"}, 32'(st_missed), 32'(pass && cfg_monitor));
    check({req, " st_group"}, 32'(st_group), 32'(a[40]));
    @(negedge clk);
    check({req, " done pulse R9"}, 32'(done_valid), 0);
  endtask

  task automatic run_frame(logic [47:0] a, int len, bit ce, bit ae, string req);
    send_addr(a, req);
    end_frame(a, len, ce, ae, req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 outputs", {20'd0, addr_dec_valid, addr_hit, addr_group, done_valid,
          frame_store, st_good, st_crc, st_align, st_missed, st_group, rx_off, 1'b0}, 0);
  endtask

  task automatic t_unicast;
    run_frame(48'h021A2B3C4D5E, 100, 0, 0, "R1 exact");
    run_frame(48'h021A2B3C4D5F, 100, 0, 0, "R1 last byte differs");
    run_frame(48'h061A2B3C4D5E, 100, 0, 0, "R1 first byte differs");
  endtask

  task automatic t_promisc;
    cfg_promisc = 1;
    run_frame(48'h0A0B0C0D0E0F, 100, 0, 0, "R2 promisc");
    cfg_promisc = 0;
    run_frame(48'h0A0B0C0D0E0F, 100, 0, 0, "R2 promisc off");
  endtask

  task automatic t_bcast;
    cfg_take_bcast = 1;
    run_frame(48'hFFFFFFFFFFFF, 100, 0, 0, "R3 bcast on R5");
    cfg_take_bcast = 0; cfg_promisc = 1; cfg_take_mcast = 1; hash_table = '1;
    run_frame(48'hFFFFFFFFFFFF, 100, 0, 0, "R3 bcast off");
    cfg_promisc = 0; cfg_take_mcast = 0; hash_table = '0;
  endtask

  task automatic t_mcast;
    logic [47:0] m1, m2;
    m1 = 48'h01005E0000FB;
    m2 = 48'h3333000000FB;
    cfg_take_mcast = 1;
    hash_table = 64'd1 << ref_idx(m1);
    run_frame(m1, 100, 0, 0, "R4 hash bit set");
    if (ref_idx(m2) != ref_idx(m1)) run_frame(m2, 100, 0, 0, "R4 other bit clear");
    hash_table = ~(64'd1 << ref_idx(m1));
    run_frame(m1, 100, 0, 0, "R4 hash bit clear");
    hash_table = '1; cfg_take_mcast = 0;
    run_frame(m1, 100, 0, 0, "R4 mcast disabled");
    hash_table = '0;
  endtask

  task automatic t_runt;
    run_frame(station_addr, 63, 0, 0, "R6 len 63");
    run_frame(station_addr, 64, 0, 0, "R6 len 64");
    cfg_keep_short = 1;
    run_frame(station_addr, 63, 0, 0, "R6 keep short");
    cfg_keep_short = 0;
  endtask

  task automatic t_err;
    run_frame(station_addr, 100, 1, 0, "R7 crc drop");
    run_frame(station_addr, 100, 0, 1, "R7 align drop");
    cfg_keep_err = 1;
    run_frame(station_addr, 100, 0, 1, "R7 keep align");
    run_frame(station_addr, 100, 1, 0, "R7 keep crc");
    cfg_keep_err = 0;
  endtask

  task automatic t_monitor;
    cfg_monitor = 1;
    @(negedge clk);
    check("R8 rx_off on", 32'(rx_off), 1);
    run_frame(station_addr, 100, 0, 0, "R8 monitor pass");
    check("R8 rx_off held", 32'(rx_off), 1);
    run_frame(48'h0A0B0C0D0E0F, 100, 0, 0, "R8 monitor miss");
    cfg_monitor = 0;
    @(negedge clk);
    check("R8 rx_off off", 32'(rx_off), 0);
  endtask

  initial begin
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_unicast();
    t_promisc();
    t_bcast();
    t_mcast();
    t_runt();
    t_err();
    t_monitor();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule